// File: doc/BRIEF.md
# Distributed Backplane Arbitration Competitor

This block is one participant in an arbitration scheme spread across several cards that share an open-drain backplane bus. Each participant holds an arbitration number and a parity bit that it captures from its local port. When the competition input is driven low, every participant pulls its number onto the shared active-low lines. A participant withdraws its lower bits as soon as it sees a higher bit asserted that it does not own itself. The bus then settles to the largest number on it, and only the owner of that number raises its win flag.

The shared lines form a wired-AND: a line reads low whenever any participant pulls it low. A participant that loses can read the settled bus back through its local port and so learn the winning number. The winner alone may pull the shared parity line. While no competition is running, a participant drives nothing and may capture a new number for the next round.

Top module: `arb_competitor`

## Requirements
- R1: While `le` is low the number and parity on `num_in`/`par_in` are captured at every clock edge. While `le` is high the captured values hold and changes on `num_in` have no effect.
- R2: A bus line reads low (0) to mean the value 1. Bit NUM_W-1 is the most significant and bit 0 the least significant, on both the local side and the bus side. A pull output of 1 pulls that line low.
- R3: After NUM_W clock edges with `compete_n` low, the bus carries the inverse of the largest number among the participants whose drivers are enabled.
- R4: `win` is 0 while `compete_n` is high and through the first SETTLE edges of a competition. From edge SETTLE+1 on, `win` is 1 exactly when the participant's drivers are enabled and its number is the largest on the bus. Numbers are assumed distinct.
- R5: The drivers are enabled only when `bus_oe` is 1 and `bus_oe_n` is 0. Otherwise `bus_pull` and `par_pull` are all 0.
- R6: A participant pulls only lines where its own number has a 1. When it wins, the bus shows its number.
- R7: When `loc_oe` is 1, `loc_out` equals the bitwise inverse of `bus_in` and `loc_out_en` is 1. When `loc_oe` is 0, `loc_out` is 0 and `loc_out_en` is 0, which stands for high impedance.
- R8: `par_pull` is 1 exactly when `win` is 1, the captured parity bit is 1, and the drivers are enabled.
- R9: While `compete_n` is high no bus line or parity line is pulled. A number captured during that idle time takes part in the next competition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| le | input | 1 | Latch control: low captures, high holds |
| num_in | input | NUM_W | Local arbitration number |
| par_in | input | 1 | Local parity bit |
| compete_n | input | 1 | Active-low competition request |
| bus_oe | input | 1 | Active-high bus driver enable |
| bus_oe_n | input | 1 | Active-low bus driver enable |
| loc_oe | input | 1 | Local readback output enable |
| bus_in | input | NUM_W | Resolved active-low bus lines |
| bus_pull | output | NUM_W | Pull-down enables for the bus lines |
| par_pull | output | 1 | Pull-down enable for the bus parity line |
| loc_out | output | NUM_W | Inverted bus readback |
| loc_out_en | output | 1 | Readback drive enable (0 means high impedance) |
| win | output | 1 | Competition won |

## Verification
The bench builds three participants with NUM_W = 8 and SETTLE = 8 and joins them through a wired-AND bus model. The settle count therefore equals the bit width. This means the worst case, where each bus bit resolves one edge after the bit above it, must finish exactly on the last edge before `win` is allowed to rise. The chosen numbers include neighbours across the most significant bit (0x81, 0x80, 0x7F) and interleaved patterns (0x55 against 0xAA), so the withdrawal of lower bits is tested in every position.

// File: rtl/arbc_pkg.sv
package arbc_pkg;
  localparam int unsigned ARBC_NUM_W  = 8;
  localparam int unsigned ARBC_SETTLE = 8;
endpackage

// File: rtl/arbc_rst_sync.sv
module arbc_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/arbc_latch.sv
module arbc_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic [W-1:0] d,
  input  logic         dp,
  output logic [W-1:0] q,
  output logic         qp
);
  logic [W-1:0] q_d;
  logic         qp_d;
  logic         cap_en;

  assign cap_en = ~hold;

  always_comb begin
    q_d  = q;
    qp_d = qp;
    if (cap_en) begin
      q_d  = d;
      qp_d = dp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q  <= '0;
      qp <= 1'b0;
    end else begin
      q  <= q_d;
      qp <= qp_d;
    end
  end
endmodule

// File: rtl/arbc_withdraw.sv
module arbc_withdraw #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic [W-1:0] own,
  input  logic [W-1:0] seen,
  output logic [W-1:0] drive_q
);
  logic [W-1:0] lose;
  logic [W-1:0] cut;
  logic [W-1:0] drive_d;

  // a bit is lost where the bus shows a 1 that this participant lacks
  assign lose = seen & ~own;

  assign cut[W-1] = 1'b0;
  for (genvar g = 0; g < W - 1; g++) begin : g_cut
    assign cut[g] = |lose[W-1:g+1];
  end

  always_comb begin
    drive_d = '0;
    if (active) drive_d = own & ~cut;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drive_q <= '0;
    else        drive_q <= drive_d;
  end
endmodule

// File: rtl/arbc_settle.sv
module arbc_settle #(
  parameter int unsigned SETTLE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic match,
  output logic win_q
);
  localparam int unsigned CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(SETTLE);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          settled;
  logic          win_d;

  assign settled = (cnt_q == CNT_TOP);

  always_comb begin
    cnt_d = '0;
    if (active) begin
      if (settled) cnt_d = cnt_q;
      else         cnt_d = cnt_q + CW'(1);
    end
    win_d = active & settled & match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      win_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      win_q <= win_d;
    end
  end
endmodule

// File: rtl/arb_competitor.sv
module arb_competitor
  import arbc_pkg::*;
#(
  parameter int unsigned NUM_W  = ARBC_NUM_W,
  parameter int unsigned SETTLE = ARBC_SETTLE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             le,
  input  logic [NUM_W-1:0] num_in,
  input  logic             par_in,
  input  logic             compete_n,
  input  logic             bus_oe,
  input  logic             bus_oe_n,
  input  logic             loc_oe,
  input  logic [NUM_W-1:0] bus_in,
  output logic [NUM_W-1:0] bus_pull,
  output logic             par_pull,
  output logic [NUM_W-1:0] loc_out,
  output logic             loc_out_en,
  output logic             win
);
  logic             rst_n_int;
  logic [NUM_W-1:0] num_q;
  logic             par_q;
  logic [NUM_W-1:0] drive_q;
  logic [NUM_W-1:0] seen;
  logic             active;
  logic             drv_en;
  logic             match;
  logic             win_q;

  assign active = ~compete_n;
  assign drv_en = bus_oe & ~bus_oe_n;
  assign seen   = ~bus_in;
  assign match  = drv_en & (seen == num_q);

  arbc_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  arbc_latch #(.W(NUM_W)) u_latch (
    .clk   (clk),
    .rst_n (rst_n_int),
    .hold  (le),
    .d     (num_in),
    .dp    (par_in),
    .q     (num_q),
    .qp    (par_q)
  );

  arbc_withdraw #(.W(NUM_W)) u_wd (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .active  (active),
    .own     (num_q),
    .seen    (seen),
    .drive_q (drive_q)
  );

  arbc_settle #(.SETTLE(SETTLE)) u_st (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .active (active),
    .match  (match),
    .win_q  (win_q)
  );

  assign win        = win_q & active;
  assign bus_pull   = drive_q & {NUM_W{drv_en & active}};
  assign par_pull   = win & par_q & drv_en;
  assign loc_out    = loc_oe ? seen : '0;
  assign loc_out_en = loc_oe;
endmodule

// File: rtl/arbc_checker.sv
module arbc_checker #(
  parameter int unsigned NUM_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             le,
  input logic             compete_n,
  input logic             bus_oe,
  input logic             bus_oe_n,
  input logic             loc_oe,
  input logic [NUM_W-1:0] bus_in,
  input logic [NUM_W-1:0] bus_pull,
  input logic             par_pull,
  input logic [NUM_W-1:0] loc_out,
  input logic             win,
  input logic [NUM_W-1:0] num_q,
  input logic             par_q
);
  assert_latch_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    le |=> $stable(num_q));

  assert_no_win_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    compete_n |-> !win);

  assert_win_after_compete_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win) |-> $past(!compete_n));

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_oe && !bus_oe_n) |-> (bus_pull == '0) && !par_pull);

  assert_own_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_pull & ~num_q) == '0);

  assert_winner_on_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    win |-> (~bus_in == num_q));

  assert_readback_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !loc_oe |-> (loc_out == '0));

  assert_parity_R8: assert property (@(posedge clk) disable iff (!rst_n)
    par_pull |-> (win && par_q));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    compete_n |-> (bus_pull == '0) && !par_pull);
endmodule

bind arb_competitor arbc_checker #(.NUM_W(NUM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .le        (le),
  .compete_n (compete_n),
  .bus_oe    (bus_oe),
  .bus_oe_n  (bus_oe_n),
  .loc_oe    (loc_oe),
  .bus_in    (bus_in),
  .bus_pull  (bus_pull),
  .par_pull  (par_pull),
  .loc_out   (loc_out),
  .win       (win),
  .num_q     (num_q),
  .par_q     (par_q)
);

// File: tb/sim_arb_competitor.sv
module sim_arb_competitor;
  localparam int W  = 8;
  localparam int ST = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n, le, compete_n;
  logic [W-1:0] num_in [3];
  logic         par_in [3], bus_oe [3], bus_oe_n [3], loc_oe [3];
  logic [W-1:0] pull [3], lo [3];
  logic         pp [3], winv [3], loe [3];
  logic [W-1:0] bus;
  logic         pbus;

  assign bus  = ~(pull[0] | pull[1] | pull[2]);
  assign pbus = ~(pp[0] | pp[1] | pp[2]);

  arb_competitor #(.NUM_W(W), .SETTLE(ST)) u0 (
    .clk(clk), .rst_n(rst_n), .le(le), .num_in(num_in[0]), .par_in(par_in[0]),
    .compete_n(compete_n), .bus_oe(bus_oe[0]), .bus_oe_n(bus_oe_n[0]),
    .loc_oe(loc_oe[0]), .bus_in(bus), .bus_pull(pull[0]), .par_pull(pp[0]),
    .loc_out(lo[0]), .loc_out_en(loe[0]), .win(winv[0]));
  arb_competitor #(.NUM_W(W), .SETTLE(ST)) u1 (
    .clk(clk), .rst_n(rst_n), .le(le), .num_in(num_in[1]), .par_in(par_in[1]),
    .compete_n(compete_n), .bus_oe(bus_oe[1]), .bus_oe_n(bus_oe_n[1]),
    .loc_oe(loc_oe[1]), .bus_in(bus), .bus_pull(pull[1]), .par_pull(pp[1]),
    .loc_out(lo[1]), .loc_out_en(loe[1]), .win(winv[1]));
  arb_competitor #(.NUM_W(W), .SETTLE(ST)) u2 (
    .clk(clk), .rst_n(rst_n), .le(le), .num_in(num_in[2]), .par_in(par_in[2]),
    .compete_n(compete_n), .bus_oe(bus_oe[2]), .bus_oe_n(bus_oe_n[2]),
    .loc_oe(loc_oe[2]), .bus_in(bus), .bus_pull(pull[2]), .par_pull(pp[2]),
    .loc_out(lo[2]), .loc_out_en(loe[2]), .win(winv[2]));

  int errs = 0;
  int checks = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference state
  int           ecnt;
  logic [W-1:0] mnum [3];
  logic         mpar [3];

  always @(posedge clk) begin
    if (!rst_n) begin
      ecnt <= 0;
      for (int i = 0; i < 3; i++) begin mnum[i] <= '0; mpar[i] <= 1'b0; end
    end else begin
      ecnt <= compete_n ? 0 : (ecnt < 1000 ? ecnt + 1 : ecnt);
      for (int i = 0; i < 3; i++)
        if (!le) begin mnum[i] <= num_in[i]; mpar[i] <= par_in[i]; end
    end
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [W-1:0] mx;
      logic         en [3];
      logic         ew [3];
      logic         ep;
      mx = '0;
      for (int i = 0; i < 3; i++) begin
        en[i] = bus_oe[i] && !bus_oe_n[i];
        if (en[i] && mnum[i] > mx) mx = mnum[i];
      end
      ep = 1'b1;
      for (int i = 0; i < 3; i++) begin
        ew[i] = !compete_n && (ecnt >= ST + 1) && en[i] && (mnum[i] == mx);
        if (ew[i] && mpar[i]) ep = 1'b0;
        chk(winv[i] == ew[i], "R4 win", 32'(winv[i]), 32'(ew[i]));
      end
      if (compete_n) chk(bus == '1, "R9 idle bus", 32'(bus), 32'hFF);
      else if (ecnt >= W) chk(bus == ~mx, "R3 settled bus", 32'(bus), 32'(~mx));
      chk(pbus == ep, "R8 parity line", 32'(pbus), 32'(ep));
      if (loc_oe[0]) chk(lo[0] == ~bus && loe[0], "R7 readback", 32'(lo[0]), 32'(~bus));
      else           chk(lo[0] == '0 && !loe[0], "R7 readback off", 32'(lo[0]), 32'h0);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic load(input logic [W-1:0] a, b, c, input logic pa, pb, pc);
    tick();
    le = 1'b0;
    num_in[0] = a; num_in[1] = b; num_in[2] = c;
    par_in[0] = pa; par_in[1] = pb; par_in[2] = pc;
    tick();
    le = 1'b1;
  endtask

  // start a competition and stop at the negedge after edge k
  task automatic compete(input int k);
    tick();
    compete_n = 1'b0;
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    tick();
    compete_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; le = 1'b1; compete_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      num_in[i] = '0; par_in[i] = 1'b0;
      bus_oe[i] = 1'b1; bus_oe_n[i] = 1'b0; loc_oe[i] = 1'b0;
    end
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(winv[0] == 1'b0, "R4 reset win", 32'(winv[0]), 0);
    chk(bus == '1, "R9 reset bus", 32'(bus), 32'hFF);
    chk(pbus == 1'b1, "R8 reset parity", 32'(pbus), 1);

    // S1: u0 highest, parity 1, boundary of the settle window
    load(8'hA5, 8'h3C, 8'h5A, 1'b1, 1'b0, 1'b0);
    loc_oe[0] = 1'b1;
    compete(ST);
    chk(winv[0] == 1'b0, "R4 no win at edge SETTLE", 32'(winv[0]), 0);
    @(posedge clk); @(negedge clk);
    chk(winv[0] == 1'b1, "R4 win at edge SETTLE+1", 32'(winv[0]), 1);
    chk(bus == ~8'hA5, "R6 winner on bus", 32'(~bus), 32'hA5);
    chk(pbus == 1'b0, "R8 winner parity pulled", 32'(pbus), 0);
    chk(lo[0] == 8'hA5, "R7 readback winner", 32'(lo[0]), 32'hA5);
    idle();
    chk(winv[0] == 1'b0, "R9 win drops when idle", 32'(winv[0]), 0);
    chk(pull[0] == '0, "R9 no pull when idle", 32'(pull[0]), 0);

    // S2: relatch while idle, then changes with le high are ignored
    load(8'h12, 8'h3C, 8'h5A, 1'b0, 1'b0, 1'b0);
    tick();
    num_in[0] = 8'hFF; par_in[0] = 1'b1;
    compete(ST + 3);
    chk(winv[0] == 1'b0, "R1 held number loses", 32'(winv[0]), 0);
    chk(winv[2] == 1'b1, "R9 relatched round winner", 32'(winv[2]), 1);
    chk(lo[0] == 8'h5A, "R7 loser reads winner", 32'(lo[0]), 32'h5A);
    chk(pbus == 1'b1, "R8 parity 0 winner", 32'(pbus), 1);
    chk((pull[0] & ~8'h12) == '0, "R1 pulls only latched bits", 32'(pull[0]), 0);
    idle();

    // S3: neighbours across the most significant bit
    load(8'h81, 8'h80, 8'h7F, 1'b0, 1'b1, 1'b1);
    compete(ST + 2);
    chk(winv[0] == 1'b1, "R2 msb ordering", 32'(winv[0]), 1);
    chk(bus == 8'h7E, "R2 active-low bus", 32'(bus), 32'h7E);
    chk(pbus == 1'b1, "R8 loser parity ignored", 32'(pbus), 1);
    idle();

    // S4: largest number with drivers disabled by either enable
    load(8'hFF, 8'h80, 8'h7F, 1'b1, 1'b0, 1'b0);
    bus_oe_n[0] = 1'b1;
    compete(ST + 2);
    chk(pull[0] == '0 && !pp[0], "R5 released low-active enable", 32'(pull[0]), 0);
    chk(winv[1] == 1'b1 && winv[0] == 1'b0, "R5 enabled max wins", 32'(winv[1]), 1);
    chk(bus == ~8'h80, "R5 bus excludes disabled", 32'(~bus), 32'h80);
    idle();
    bus_oe_n[0] = 1'b0; bus_oe[0] = 1'b0;
    compete(ST + 2);
    chk(pull[0] == '0 && winv[0] == 1'b0, "R5 released high-active enable", 32'(pull[0]), 0);
    idle();
    bus_oe[0] = 1'b1;

    // S5: interleaved patterns, readback disabled
    load(8'h55, 8'hAA, 8'h54, 1'b1, 1'b1, 1'b0);
    loc_oe[0] = 1'b0;
    compete(W);
    chk(bus == ~8'hAA, "R3 settled after NUM_W edges", 32'(~bus), 32'hAA);
    chk((pull[0] & ~8'h55) == '0, "R6 only own bits", 32'(pull[0]), 0);
    chk(lo[0] == '0 && !loe[0], "R7 high impedance", 32'(lo[0]), 0);
    @(posedge clk); @(negedge clk);
    chk(winv[1] == 1'b1 && pbus == 1'b0, "R8 winner parity 1", 32'(pbus), 0);
    idle();

    // S6: smallest nonzero against zero
    load(8'h01, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    compete(ST + 1);
    chk(winv[0] == 1'b1 && bus == 8'hFE, "R3 lsb competition", 32'(bus), 32'hFE);
    idle();

    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule